// File: doc/BRIEF.md
# Serialization-Aware Dual Dispatch Controller

This controller sits between the two oldest entries of an instruction queue and the decode stage of a dual-issue pipeline. In every cycle it decides how many of those entries, zero, one or two, may move into decode. Each entry carries a two-bit serialization class. The controller applies three strengths of ordering. The first holds an entry in the queue until everything older has completed. The second lets an entry decode but then stops all decode until that entry reports completion. The third lets an entry decode and then holds it in its reservation station until it is the oldest instruction in flight.

The class encoding is fixed: 0 is plain, 1 is presync (wait before decode), 2 is postsync (block decode after it until it completes), and 3 is move-from (wait in the reservation station). Slot 0 is the older queue entry. The controller records the tag of a granted postsync entry and watches the completion bus for that tag. It also tracks one waiting move-from entry, and raises a one-cycle execute enable for it once the reservation station reports that entry as oldest. A branch-mispredict flush discards both kinds of pending state.

Top module: `ser_dispatch_ctrl`

## Requirements
- R1: While reset is high, the grant is 0 and the execute enable is low. Reset leaves no postsync block and no waiting move-from entry.
- R2: With no block in place, two valid plain entries are granted 2 and a lone valid plain slot 0 entry is granted 1. Nothing is granted unless slot 0 is valid. The all-prior-done input has no effect on plain entries.
- R3: A presync (class 1) entry in slot 0 is granted 1 only in a cycle where all-prior-done is high. Otherwise the grant is 0.
- R4: A postsync (class 2) entry in slot 0 is granted alone, and its tag is recorded. From the next cycle on, the grant stays 0 until the cycle after a completion whose tag equals the recorded one. Completions that carry other tags have no effect.
- R5: When slot 0 is plain and slot 1 holds any serializing class (1, 2 or 3), only slot 0 is granted (grant 1).
- R6: A move-from (class 3) entry in slot 0 is granted alone even when all-prior-done is low. While it waits, younger plain entries keep dispatching in pairs.
- R7: The execute enable goes high for exactly one cycle. That cycle is the one after a cycle in which a move-from entry was waiting and the oldest-in-flight input was high.
- R8: While a move-from entry is waiting, another move-from entry in slot 0 gets grant 0. It is granted in the same cycle that the execute enable of the earlier entry is high.
- R9: In a flush cycle the grant is 0. After a flush, decode is no longer blocked and no execute enable follows for a move-from entry that was waiting.
- R10: The oldest-in-flight input has no effect on the execute enable when no move-from entry is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iq_vld | input | 2 | Valid bits of queue slots 1 and 0 (slot 0 older) |
| iq_cls0 | input | 2 | Serialization class of slot 0 |
| iq_cls1 | input | 2 | Serialization class of slot 1 |
| iq_tag0 | input | TAG_W | Completion tag of slot 0 |
| all_prior_done | input | 1 | Every instruction granted so far has completed |
| flush | input | 1 | Branch-mispredict flush |
| cpl_vld | input | 1 | A completion is reported this cycle |
| cpl_tag | input | TAG_W | Tag of the completing instruction |
| rs_mf_oldest | input | 1 | The waiting move-from entry is the oldest in flight |
| dec_grant | output | 2 | Number of entries sent to decode this cycle |
| mf_exec_en | output | 1 | One-cycle start of the waiting move-from entry |

## Verification
A stuck or lost postsync block shows at the grant output in the first cycle after the fault: the grant either stays 0 after the matching completion or rises above 0 while the block should still hold. A wrong recorded tag shows the same way, in the cycle after the completion that should have released decode. A move-from tracker in the wrong state shows in one of two ways within one cycle. The execute enable pulses late, twice or without an oldest report, or a second move-from entry is granted while the first is still waiting. A flush that fails to clear state shows either as an execute enable after the flush or as a grant of 0 in the following cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        SC_PLAIN    = 2'd0,
        SC_PRE      = 2'd1,
        SC_POST     = 2'd2,
        SC_MOVEFROM = 2'd3
    } ser_cls_e;

    typedef struct packed {
        logic     vld;
        ser_cls_e cls;
    } q_slot_t;

    typedef struct packed {
        logic take0;
        logic take1;
        logic arm_post;
        logic arm_mf;
    } dec_ctl_t;

    function automatic logic is_serial(ser_cls_e c);
        return c != SC_PLAIN;
    endfunction

    function automatic logic [1:0] grant_count(dec_ctl_t d);
        return {1'b0, d.take0} + {1'b0, d.take1};
    endfunction

endpackage

// File: rtl/sdc_grant.sv
module sdc_grant
    import sdc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  q_slot_t  s0,
    input  q_slot_t  s1,
    input  logic     prior_done,
    input  logic     flush,
    input  logic     post_blocked,
    input  logic     mf_busy,
    output dec_ctl_t dec
);

    always_comb begin
        dec = '0;
        if (!rst && !flush && !post_blocked && s0.vld) begin
            unique case (s0.cls)
                SC_PLAIN: begin
                    dec.take0 = 1'b1;
                    dec.take1 = s1.vld && !is_serial(s1.cls);
                end
                SC_PRE: begin
                    dec.take0 = prior_done;
                end
                SC_POST: begin
                    dec.take0    = 1'b1;
                    dec.arm_post = 1'b1;
                end
                SC_MOVEFROM: begin
                    dec.take0  = !mf_busy;
                    dec.arm_mf = !mf_busy;
                end
                default: dec = '0;
            endcase
        end
    end

    // R5: a pair grant only ever carries two plain entries
    p_pair_plain_r5: assert property (@(posedge clk) disable iff (rst)
        dec.take1 |-> (s0.cls == SC_PLAIN && s1.cls == SC_PLAIN && dec.take0));

    // R3: presync never leaves the queue while older work is outstanding
    p_presync_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (s0.vld && s0.cls == SC_PRE && !prior_done) |-> !dec.take0);

    // R8: a second move-from is held while one waits
    p_mf_single_r8: assert property (@(posedge clk) disable iff (rst)
        (mf_busy && s0.cls == SC_MOVEFROM) |-> !dec.take0);

endmodule

// File: rtl/sdc_post_block.sv
module sdc_post_block #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             arm,
    input  logic [TAG_W-1:0] arm_tag,
    input  logic             cpl_vld,
    input  logic [TAG_W-1:0] cpl_tag,
    output logic             blocked
);

    logic [TAG_W-1:0] held_tag;
    logic             hit;

    assign hit = blocked && cpl_vld && (cpl_tag == held_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            blocked  <= 1'b0;
            held_tag <= '0;
        end else if (flush) begin
            blocked <= 1'b0;
        end else if (arm) begin
            blocked  <= 1'b1;
            held_tag <= arm_tag;
        end else if (hit) begin
            blocked <= 1'b0;
        end
    end

    // R9: a flush always lifts the block
    p_flush_unblock_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !blocked);

    // R4: a block only ends through a completion or a flush
    p_block_release_r4: assert property (@(posedge clk) disable iff (rst)
        (blocked && !flush && !cpl_vld) |=> blocked);

endmodule

// File: rtl/sdc_mf_track.sv
module sdc_mf_track (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic arm,
    input  logic oldest,
    output logic busy,
    output logic go
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy <= 1'b0;
            go   <= 1'b0;
        end else begin
            go <= busy && oldest;
            if (busy && oldest)
                busy <= 1'b0;
            else if (arm)
                busy <= 1'b1;
        end
    end

    // R7: the enable follows a waiting entry seen as oldest
    p_go_after_oldest_r7: assert property (@(posedge clk) disable iff (rst)
        go |-> $past(busy && oldest));

    // R7: the enable lasts a single cycle
    p_go_single_r7: assert property (@(posedge clk) disable iff (rst)
        go |=> !go);

    // R10: nothing waiting, nothing started
    p_no_spurious_go_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !flush) |=> !go);

endmodule

// File: rtl/ser_dispatch_ctrl.sv
module ser_dispatch_ctrl
    import sdc_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       iq_vld,
    input  logic [1:0]       iq_cls0,
    input  logic [1:0]       iq_cls1,
    input  logic [TAG_W-1:0] iq_tag0,
    input  logic             all_prior_done,
    input  logic             flush,
    input  logic             cpl_vld,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic             rs_mf_oldest,
    output logic [1:0]       dec_grant,
    output logic             mf_exec_en
);

    q_slot_t  s0, s1;
    dec_ctl_t dec;
    logic     post_blocked;
    logic     mf_busy;

    assign s0 = '{vld: iq_vld[0], cls: ser_cls_e'(iq_cls0)};
    assign s1 = '{vld: iq_vld[1], cls: ser_cls_e'(iq_cls1)};

    sdc_grant u_grant (
        .clk          (clk),
        .rst          (rst),
        .s0           (s0),
        .s1           (s1),
        .prior_done   (all_prior_done),
        .flush        (flush),
        .post_blocked (post_blocked),
        .mf_busy      (mf_busy),
        .dec          (dec)
    );

    sdc_post_block #(.TAG_W(TAG_W)) u_post (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .arm     (dec.arm_post),
        .arm_tag (iq_tag0),
        .cpl_vld (cpl_vld),
        .cpl_tag (cpl_tag),
        .blocked (post_blocked)
    );

    sdc_mf_track u_mf (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .arm    (dec.arm_mf),
        .oldest (rs_mf_oldest),
        .busy   (mf_busy),
        .go     (mf_exec_en)
    );

    assign dec_grant = grant_count(dec);

    // R1: reset holds both outputs quiet
    always_comb begin
        if (rst) begin
            p_reset_quiet_r1: assert (dec_grant == 2'd0);
        end
    end

    // R4: while the postsync block stands, decode is closed
    p_block_no_grant_r4: assert property (@(posedge clk) disable iff (rst)
        post_blocked |-> (dec_grant == 2'd0));

    // R2: the grant never exceeds the dispatch width
    p_grant_range_r2: assert property (@(posedge clk) disable iff (rst)
        dec_grant != 2'd3);

    // R9: flush cycle grants nothing
    p_flush_no_grant_r9: assert property (@(posedge clk) disable iff (rst)
        flush |-> (dec_grant == 2'd0));

endmodule

// File: tb/test_ser_dispatch_ctrl.sv
module test_ser_dispatch_ctrl;

    localparam int TAG_W = 4;
    localparam logic [1:0] N = 2'd0, P = 2'd1, S = 2'd2, M = 2'd3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       iq_vld = '0;
    logic [1:0]       iq_cls0 = '0;
    logic [1:0]       iq_cls1 = '0;
    logic [TAG_W-1:0] iq_tag0 = '0;
    logic             all_prior_done = 1'b0;
    logic             flush = 1'b0;
    logic             cpl_vld = 1'b0;
    logic [TAG_W-1:0] cpl_tag = '0;
    logic             rs_mf_oldest = 1'b0;
    logic [1:0]       dec_grant;
    logic             mf_exec_en;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ser_dispatch_ctrl #(.TAG_W(TAG_W)) i_ser_dispatch_ctrl (
        .clk(clk), .rst(rst), .iq_vld(iq_vld), .iq_cls0(iq_cls0), .iq_cls1(iq_cls1),
        .iq_tag0(iq_tag0), .all_prior_done(all_prior_done), .flush(flush),
        .cpl_vld(cpl_vld), .cpl_tag(cpl_tag), .rs_mf_oldest(rs_mf_oldest),
        .dec_grant(dec_grant), .mf_exec_en(mf_exec_en)
    );

    // {vld[1:0], cls0, cls1, prior_done, expected grant}
    localparam int NV = 12;
    localparam logic [8:0] VEC [NV] = '{
        {2'b11, N, N, 1'b1, 2'd2},   // R2
        {2'b11, N, N, 1'b0, 2'd2},   // R2
        {2'b01, N, N, 1'b1, 2'd1},   // R2
        {2'b00, N, N, 1'b1, 2'd0},   // R2
        {2'b10, N, N, 1'b1, 2'd0},   // R2
        {2'b11, P, N, 1'b0, 2'd0},   // R3
        {2'b11, P, N, 1'b1, 2'd1},   // R3
        {2'b11, N, P, 1'b1, 2'd1},   // R5
        {2'b11, N, S, 1'b1, 2'd1},   // R5
        {2'b11, N, M, 1'b1, 2'd1},   // R5
        {2'b11, S, N, 1'b1, 2'd1},   // R4
        {2'b11, M, N, 1'b0, 2'd1}    // R6
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] v, input logic [1:0] a, input logic [1:0] b,
                       input logic pd, input logic fl, input logic cv,
                       input logic [TAG_W-1:0] ct, input logic [TAG_W-1:0] t0,
                       input logic ro);
        @(negedge clk);
        iq_vld = v; iq_cls0 = a; iq_cls1 = b; all_prior_done = pd;
        flush = fl; cpl_vld = cv; cpl_tag = ct; iq_tag0 = t0; rs_mf_oldest = ro;
        #2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset behaviour
        put(2'b11, N, N, 1, 0, 0, 0, 0, 1);
        chk("R1 grant in reset", dec_grant, 0);
        put(2'b11, M, N, 1, 0, 0, 0, 0, 1);
        chk("R1 grant in reset", dec_grant, 0);
        chk("R1 enable in reset", mf_exec_en, 0);
        rst = 1'b1;
        put(2'b00, N, N, 1, 0, 0, 0, 0, 0);
        rst = 1'b0;
        put(2'b11, N, N, 1, 0, 0, 0, 0, 0);
        chk("R1 clean state after reset", dec_grant, 2);

        // table walk, each vector followed by a flush cycle
        for (int i = 0; i < NV; i++) begin
            put(VEC[i][8:7], VEC[i][6:5], VEC[i][4:3], VEC[i][2], 0, 0, 0, 0, 0);
            chk($sformatf("vector %0d (R2/R3/R4/R5/R6)", i), dec_grant, int'(VEC[i][1:0]));
            put(2'b11, N, N, 1, 1, 0, 0, 0, 0);
            chk("R9 flush cycle grant", dec_grant, 0);
        end

        // R4: postsync blocking and tag match
        put(2'b11, S, N, 1, 0, 0, 0, 5, 0);
        chk("R4 postsync alone", dec_grant, 1);
        put(2'b11, N, N, 1, 0, 0, 0, 0, 0);
        chk("R4 blocked", dec_grant, 0);
        put(2'b11, N, N, 1, 0, 1, 3, 0, 0);
        chk("R4 blocked at other tag", dec_grant, 0);
        put(2'b11, N, N, 1, 0, 0, 0, 0, 0);
        chk("R4 other tag ignored", dec_grant, 0);
        put(2'b11, N, N, 1, 0, 1, 5, 0, 0);
        chk("R4 still blocked in completion cycle", dec_grant, 0);
        put(2'b11, N, N, 1, 0, 0, 0, 0, 0);
        chk("R4 released after match", dec_grant, 2);

        // R6/R7/R8: move-from waiting
        put(2'b11, M, N, 0, 0, 0, 0, 0, 0);
        chk("R6 move-from alone", dec_grant, 1);
        put(2'b11, N, N, 0, 0, 0, 0, 0, 0);
        chk("R6 younger pair flows", dec_grant, 2);
        chk("R7 no early enable", mf_exec_en, 0);
        put(2'b11, M, N, 1, 0, 0, 0, 0, 1);
        chk("R8 second move-from held", dec_grant, 0);
        chk("R7 enable not same cycle", mf_exec_en, 0);
        put(2'b11, M, N, 1, 0, 0, 0, 0, 0);
        chk("R7 enable next cycle", mf_exec_en, 1);
        chk("R8 second granted with enable", dec_grant, 1);
        put(2'b00, N, N, 1, 0, 0, 0, 0, 0);
        chk("R7 single pulse", mf_exec_en, 0);

        // R9: flush drops waiting move-from
        put(2'b11, N, N, 1, 1, 0, 0, 0, 1);
        chk("R9 flush grant", dec_grant, 0);
        put(2'b00, N, N, 1, 0, 0, 0, 0, 1);
        chk("R9 no enable after flush", mf_exec_en, 0);
        put(2'b00, N, N, 1, 0, 0, 0, 0, 0);
        chk("R10 oldest ignored when idle", mf_exec_en, 0);
        put(2'b11, M, N, 1, 0, 0, 0, 0, 0);
        chk("R9 tracker free after flush", dec_grant, 1);
        put(2'b00, N, N, 1, 1, 0, 0, 0, 0);

        // R9: flush lifts postsync block
        put(2'b11, S, N, 1, 0, 0, 0, 7, 0);
        chk("R4 postsync granted", dec_grant, 1);
        put(2'b11, N, N, 1, 1, 0, 0, 0, 0);
        chk("R9 flush grant", dec_grant, 0);
        put(2'b11, N, N, 1, 0, 0, 0, 0, 0);
        chk("R9 block cleared", dec_grant, 2);

        // R10: oldest pulses with nothing waiting
        put(2'b00, N, N, 1, 0, 0, 0, 0, 1);
        put(2'b00, N, N, 1, 0, 0, 0, 0, 1);
        chk("R10 no enable", mf_exec_en, 0);

        finish_run();
    end

endmodule